// File: doc/BRIEF.md
# Relaxed Value-Set Load Checker

This block watches completed memory operations reported by several processor ports over a small shared address range. Rather than predicting the one value each load must return, it keeps, for every tracked address, a short table of values that could still legally be read, each with the span of time in which it is readable. A load is accepted when its returned value was readable at some instant inside that load's own start-to-end interval. Otherwise a fault pulse goes out on the cycle the load is processed. Loads that pass also narrow the table. Once a value has been observed, stores that are provably older than it stop being readable from that load's end time onward. Entries that have been unreadable for longer than the operation latency bound are then freed.

A monitor drives one message per port: a valid bit, a store/load flag, an address, a data value and the operation's start stamp. The checker stamps the end time itself from a free-running cycle counter when it takes a batch. A batch is taken only while `ready` is high. The ports of a batch are then walked one per cycle, lowest port first. The state machine has two states. ST_IDLE takes the batch ("capture", or "hold" when nothing is valid). ST_WALK handles one port per cycle ("advance") and returns to ST_IDLE after the last port ("finish").

Top module: `value_set_checker`

## Requirements
- R1: After reset, every address holds exactly one readable candidate of value 0 from time 0, `occupancy` equals the number of addresses, `ready` is 1 and `flt_valid` is 0.
- R2: A store is inserted as a candidate readable from its start stamp. A load whose value matches no candidate raises a fault with `flt_kind` = 1 and reports its port, address and data. A load whose value matches a readable candidate raises no fault.
- R3: A candidate invalidated at time T still satisfies a load whose start stamp is earlier than T. It fails a load whose start stamp is T or later.
- R4: When a load passes, the candidate it matched becomes observed at the load's end time. Every other live candidate at that address becomes unreadable from the load's end time onward if it meets any of three conditions: it was first observed before the load started; it ended before the matched candidate began; or it came from the same port and ended no later than the matched candidate began. An earlier invalidation time is kept.
- R5: At one address, stores of 1 and 2 complete together, a load later returns 1, and a still later load returns 2. After that, a further load returning 1 is faulted with `flt_kind` = 1.
- R6: The initial value 0 stops being readable once a load at that address returns a value stored after time 0. A later load of 0 is then faulted.
- R7: A candidate that has been unreadable for more than MAX_LAT cycles is freed, which lowers `occupancy`. Occupancy never grows by more than one per cycle.
- R8: A store to an address whose table is full of live entries raises a fault with `flt_kind` = 2 carrying the store's port, address and data. The store is not inserted, so a later load of that value is faulted.
- R9: Messages of one batch are handled in increasing port order. A load sees a store from a lower port of the same batch but not one from a higher port.
- R10: A batch is taken on a clock edge where `ready` is 1 and any valid bit is set. `ready` then stays 0 for exactly NPORT cycles. The fault for a port appears for one cycle, after the edge that processes that port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | NPORT | Message present, one bit per port |
| msg_store | input | NPORT | 1 = store completion, 0 = load completion |
| msg_addr | input | NPORT x AW | Tracked address index per port |
| msg_data | input | NPORT x DATA_W | Stored or returned value per port |
| msg_tbeg | input | NPORT x TIME_W | Start stamp of the operation per port |
| ready | output | 1 | Checker is in ST_IDLE and takes a batch |
| flt_valid | output | 1 | One-cycle fault pulse |
| flt_kind | output | 2 | 1 = unexplained load value, 2 = table full |
| flt_src | output | SRC_W | Port of the faulting message |
| flt_addr | output | AW | Address of the faulting message |
| flt_data | output | DATA_W | Data of the faulting message |
| occupancy | output | OCC_W | Live candidates across all addresses |

## Verification
Some properties are checked on every cycle. These are the handshake between `ready` and batch capture, that a fault appears only right after a walk cycle, that fault codes and ports stay legal, that a full-table fault only occurs when at least DEPTH entries are live, and that occupancy rises by at most one per cycle. Other behaviour only shows up in the bench's scenarios, because it depends on the history of stores and loads. This covers the narrowing of the value sets, the stuck-order example, the late load that still passes, the loss of the zero value, retirement after the latency bound, port order within a batch and the dropped store on overflow.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    parameter int DATA_W = 8;
    parameter int TIME_W = 16;
    parameter int SRC_W  = 2;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TIME_W-1:0] stamp_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_VALUE = 2'd1,
        FLT_FULL  = 2'd2
    } fault_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

    // One candidate value for one address.
    typedef struct packed {
        logic             live;
        logic [SRC_W-1:0] src;
        data_t            data;
        stamp_t           t_beg;
        stamp_t           t_fin;
        logic             seen;
        stamp_t           t_seen;
        logic             dead;
        stamp_t           t_dead;
    } cand_t;

endpackage

// File: rtl/vsc_pick.sv
module vsc_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Lowest set request wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vsc_match.sv
module vsc_match
    import vsc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  cand_t            ents [DEPTH],
    input  data_t            ld_data,
    input  stamp_t           ld_beg,
    input  stamp_t           ld_end,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output logic [DEPTH-1:0] kill
);

    logic [DEPTH-1:0] ok;

    // Readable at some instant inside [ld_beg, ld_end].
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ok[i] = ents[i].live
                 && (ents[i].data == ld_data)
                 && (ents[i].t_beg <= ld_end)
                 && (!ents[i].dead || (ents[i].t_dead > ld_beg));
        end
    end

    vsc_pick #(.N(DEPTH), .IW(IW)) u_pick (
        .req (ok),
        .any (hit),
        .idx (hit_idx)
    );

    // Candidates provably older than the one just observed.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            kill[i] = hit
                   && ents[i].live
                   && (IW'(i) != hit_idx)
                   && ((ents[i].seen && (ents[i].t_seen < ld_beg))
                       || (ents[i].t_fin < ents[hit_idx].t_beg)
                       || ((ents[i].src == ents[hit_idx].src)
                           && (ents[i].t_fin <= ents[hit_idx].t_beg)));
        end
    end

endmodule

// File: rtl/value_set_checker.sv
module value_set_checker
    import vsc_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int NADDR   = 4,
    parameter int DEPTH   = 4,
    parameter int MAX_LAT = 64,
    localparam int AW     = (NADDR > 1) ? $clog2(NADDR) : 1,
    localparam int OCC_W  = $clog2(NADDR * DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              msg_valid,
    input  logic [NPORT-1:0]              msg_store,
    input  logic [NPORT-1:0][AW-1:0]      msg_addr,
    input  logic [NPORT-1:0][DATA_W-1:0]  msg_data,
    input  logic [NPORT-1:0][TIME_W-1:0]  msg_tbeg,
    output logic                          ready,
    output logic                          flt_valid,
    output logic [1:0]                    flt_kind,
    output logic [SRC_W-1:0]              flt_src,
    output logic [AW-1:0]                 flt_addr,
    output logic [DATA_W-1:0]             flt_data,
    output logic [OCC_W-1:0]              occupancy
);

    localparam int PIW = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    walk_state_e state_q, state_d;
    logic [PIW-1:0] pidx_q;
    stamp_t         now_q;

    logic [NPORT-1:0]             b_valid, b_store;
    logic [NPORT-1:0][AW-1:0]     b_addr;
    logic [NPORT-1:0][DATA_W-1:0] b_data;
    logic [NPORT-1:0][TIME_W-1:0] b_tbeg;
    stamp_t                       b_end;

    cand_t table_q [NADDR][DEPTH];
    cand_t row [DEPTH];

    logic       cur_valid, cur_store;
    logic [AW-1:0] cur_addr;
    data_t      cur_data;
    stamp_t     cur_tbeg;
    logic       do_store, do_load;

    logic             hit, has_free;
    logic [IW-1:0]    hit_idx, free_idx;
    logic [DEPTH-1:0] kill, free_req;
    fault_e           fault;

    // Free-running time base.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: capture / hold / advance / finish.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (|msg_valid) state_d = ST_WALK;
            ST_WALK: if (pidx_q == PIW'(NPORT - 1)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign ready = (state_q == ST_IDLE);

    // Batch capture and port walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pidx_q  <= '0;
            b_valid <= '0;
            b_store <= '0;
            b_addr  <= '0;
            b_data  <= '0;
            b_tbeg  <= '0;
            b_end   <= '0;
        end else if (state_q == ST_IDLE) begin
            pidx_q <= '0;
            if (|msg_valid) begin
                b_valid <= msg_valid;
                b_store <= msg_store;
                b_addr  <= msg_addr;
                b_data  <= msg_data;
                b_tbeg  <= msg_tbeg;
                b_end   <= now_q;
            end
        end else begin
            pidx_q <= PIW'(pidx_q + 1'b1);
        end
    end

    assign cur_valid = (state_q == ST_WALK) && b_valid[pidx_q];
    assign cur_store = b_store[pidx_q];
    assign cur_addr  = b_addr[pidx_q];
    assign cur_data  = b_data[pidx_q];
    assign cur_tbeg  = b_tbeg[pidx_q];
    assign do_store  = cur_valid && cur_store;
    assign do_load   = cur_valid && !cur_store;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            row[i]      = table_q[cur_addr][i];
            free_req[i] = !table_q[cur_addr][i].live;
        end
    end

    vsc_match #(.DEPTH(DEPTH), .IW(IW)) u_match (
        .ents    (row),
        .ld_data (cur_data),
        .ld_beg  (cur_tbeg),
        .ld_end  (b_end),
        .hit     (hit),
        .hit_idx (hit_idx),
        .kill    (kill)
    );

    vsc_pick #(.N(DEPTH), .IW(IW)) u_free (
        .req (free_req),
        .any (has_free),
        .idx (free_idx)
    );

    always_comb begin
        fault = FLT_NONE;
        if (do_store && !has_free) fault = FLT_FULL;
        if (do_load && !hit)       fault = FLT_VALUE;
    end

    // Candidate tables: sweep, insert, narrow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NADDR; a++) begin
                for (int i = 0; i < DEPTH; i++) table_q[a][i] <= '0;
                table_q[a][0].live <= 1'b1;
                table_q[a][0].seen <= 1'b1;
            end
        end else begin
            for (int a = 0; a < NADDR; a++) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (table_q[a][i].live && table_q[a][i].dead &&
                        (stamp_t'(now_q - table_q[a][i].t_dead) > stamp_t'(MAX_LAT)))
                        table_q[a][i].live <= 1'b0;
                end
            end
            if (do_store && has_free) begin
                table_q[cur_addr][free_idx] <= '{live: 1'b1, src: SRC_W'(pidx_q),
                                                data: cur_data, t_beg: cur_tbeg,
                                                t_fin: b_end, seen: 1'b0, t_seen: '0,
                                                dead: 1'b0, t_dead: '0};
            end
            if (do_load && hit) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (kill[i]) begin
                        table_q[cur_addr][i].dead   <= 1'b1;
                        table_q[cur_addr][i].t_dead <= (row[i].dead && (row[i].t_dead < b_end))
                                                       ? row[i].t_dead : b_end;
                    end
                end
                if (!row[hit_idx].seen) begin
                    table_q[cur_addr][hit_idx].seen   <= 1'b1;
                    table_q[cur_addr][hit_idx].t_seen <= b_end;
                end
            end
        end
    end

    // Registered fault report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_valid <= 1'b0;
            flt_kind  <= FLT_NONE;
            flt_src   <= '0;
            flt_addr  <= '0;
            flt_data  <= '0;
        end else begin
            flt_valid <= (fault != FLT_NONE);
            flt_kind  <= fault;
            flt_src   <= SRC_W'(pidx_q);
            flt_addr  <= cur_addr;
            flt_data  <= cur_data;
        end
    end

    always_comb begin
        occupancy = '0;
        for (int a = 0; a < NADDR; a++)
            for (int i = 0; i < DEPTH; i++)
                occupancy = occupancy + OCC_W'(table_q[a][i].live);
    end

endmodule

// File: rtl/vsc_checker_sva.sv
module vsc_checker_sva #(
    parameter int NPORT = 4,
    parameter int DEPTH = 4,
    parameter int SRC_W = 2,
    parameter int OCC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] msg_valid,
    input logic             ready,
    input logic             flt_valid,
    input logic [1:0]       flt_kind,
    input logic [SRC_W-1:0] flt_src,
    input logic [OCC_W-1:0] occupancy
);

    // R10
    walk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (|msg_valid)) |=> !ready);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(|msg_valid)) |=> ready);

    // R10
    flt_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> !$past(ready));

    // R2
    flt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> ((flt_kind == 2'd1 || flt_kind == 2'd2) && (int'(flt_src) < NPORT)));

    // R8
    full_needs_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_kind == 2'd2) |-> (int'($past(occupancy)) >= DEPTH));

    // R7
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, occupancy} <= ({1'b0, $past(occupancy)} + 1'b1)));

endmodule

bind value_set_checker vsc_checker_sva #(
    .NPORT (NPORT),
    .DEPTH (DEPTH),
    .SRC_W (vsc_pkg::SRC_W),
    .OCC_W (OCC_W)
) u_vsc_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .ready     (ready),
    .flt_valid (flt_valid),
    .flt_kind  (flt_kind),
    .flt_src   (flt_src),
    .occupancy (occupancy)
);

// File: tb/test_value_set_checker.sv
module test_value_set_checker;
    import vsc_pkg::*;

    localparam int NP    = 4;
    localparam int NA    = 4;
    localparam int DP    = 4;
    localparam int LAT   = 200;
    localparam int AW    = 2;
    localparam int OCC_W = $clog2(NA * DP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NP-1:0]             msg_valid = '0, msg_store = '0;
    logic [NP-1:0][AW-1:0]     msg_addr = '0;
    logic [NP-1:0][DATA_W-1:0] msg_data = '0;
    logic [NP-1:0][TIME_W-1:0] msg_tbeg = '0;
    logic                      ready, flt_valid;
    logic [1:0]                flt_kind;
    logic [SRC_W-1:0]          flt_src;
    logic [AW-1:0]             flt_addr;
    logic [DATA_W-1:0]         flt_data;
    logic [OCC_W-1:0]          occupancy;

    value_set_checker #(.NPORT(NP), .NADDR(NA), .DEPTH(DP), .MAX_LAT(LAT)) i_value_set_checker (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_store(msg_store),
        .msg_addr(msg_addr), .msg_data(msg_data), .msg_tbeg(msg_tbeg),
        .ready(ready), .flt_valid(flt_valid), .flt_kind(flt_kind), .flt_src(flt_src),
        .flt_addr(flt_addr), .flt_data(flt_data), .occupancy(occupancy)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    typedef struct {
        int    code;
        string req;
    } exp_t;
    exp_t expq[$];

    function automatic int pack_flt(int k, int s, int a, int d);
        return (k << 24) | (s << 16) | (a << 8) | d;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare each fault against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && flt_valid) begin
            int act;
            act = pack_flt(int'(flt_kind), int'(flt_src), int'(flt_addr), int'(flt_data));
            if (expq.size() == 0) begin
                check(1'b0, "R2", "unexpected fault kind/port/addr/data", act, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(act == e.code, e.req, "fault kind/port/addr/data", act, e.code);
            end
        end
    end

    logic [NP-1:0]             s_valid = '0, s_store = '0;
    logic [NP-1:0][AW-1:0]     s_addr = '0;
    logic [NP-1:0][DATA_W-1:0] s_data = '0;
    logic [NP-1:0][TIME_W-1:0] s_tbeg = '0;

    task automatic put(int p, bit st, int a, int d, int tb);
        s_valid[p] = 1'b1;
        s_store[p] = st;
        s_addr[p]  = AW'(a);
        s_data[p]  = DATA_W'(d);
        s_tbeg[p]  = TIME_W'(tb);
    endtask

    task automatic expect_flt(int k, int p, int a, int d, string req);
        exp_t e;
        e.code = pack_flt(k, p, a, d);
        e.req  = req;
        expq.push_back(e);
    endtask

    // Driver: entered and left at a falling edge.
    task automatic fire(output int t_end, input string req);
        int lows;
        while (!ready) @(negedge clk);
        msg_valid = s_valid;
        msg_store = s_store;
        msg_addr  = s_addr;
        msg_data  = s_data;
        msg_tbeg  = s_tbeg;
        t_end     = cyc;
        @(negedge clk);
        msg_valid = '0;
        s_valid   = '0;
        lows = 0;
        while (!ready && lows < 50) begin
            lows++;
            @(negedge clk);
        end
        check(lows == NP, "R10", "cycles with ready low", lows, NP);
        @(negedge clk);
        @(posedge clk);
        check(expq.size() == 0, req, "faults still expected", expq.size(), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int te, e8;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
        check(flt_valid == 1'b0, "R1", "fault after reset", int'(flt_valid), 0);
        check(int'(occupancy) == NA, "R1", "occupancy after reset", int'(occupancy), NA);

        // R1: initial zero is readable
        put(0, 0, 0, 0, cyc - 1);
        fire(te, "R1");

        // R2: stored value passes, never-written value fails
        put(1, 1, 1, 5, cyc - 1);
        fire(te, "R2");
        put(2, 0, 1, 5, cyc - 1);
        put(3, 0, 1, 9, cyc - 1);
        expect_flt(1, 3, 1, 9, "R2");
        fire(te, "R2");

        // R6: zero no longer readable at address 1
        put(0, 0, 1, 0, cyc - 1);
        expect_flt(1, 0, 1, 0, "R6");
        fire(te, "R6");

        // R9: port order inside one batch
        put(0, 0, 2, 7, cyc - 1);
        put(1, 1, 2, 7, cyc - 1);
        put(2, 0, 2, 7, cyc - 1);
        expect_flt(1, 0, 2, 7, "R9");
        fire(te, "R9");

        // R5: stuck-order example at address 3
        put(0, 1, 3, 1, cyc - 1);
        put(1, 1, 3, 2, cyc - 1);
        fire(te, "R5");
        put(2, 0, 3, 1, cyc - 1);
        fire(te, "R5");
        put(3, 0, 3, 2, cyc - 1);
        fire(e8, "R5");
        put(0, 0, 3, 1, cyc - 1);
        expect_flt(1, 0, 3, 1, "R5");
        fire(te, "R5");

        // R3: load that started before the invalidation still passes
        put(1, 0, 3, 1, e8 - 1);
        fire(te, "R3");

        check(int'(occupancy) == 8, "R7", "occupancy before retirement", int'(occupancy), 8);
        repeat (LAT + 30) @(negedge clk);
        check(int'(occupancy) == 4, "R7", "occupancy after retirement", int'(occupancy), 4);

        // R8: overflow at address 0
        put(0, 1, 0, 10, cyc - 1);
        put(1, 1, 0, 11, cyc - 1);
        put(2, 1, 0, 12, cyc - 1);
        put(3, 1, 0, 13, cyc - 1);
        expect_flt(2, 3, 0, 13, "R8");
        fire(te, "R8");
        check(int'(occupancy) == 7, "R8", "occupancy after overflow", int'(occupancy), 7);
        put(0, 0, 0, 13, cyc - 1);
        expect_flt(1, 0, 0, 13, "R8");
        fire(te, "R8");

        // R4: unobserved older store dropped after newer one is read
        put(0, 1, 2, 30, cyc - 1);
        fire(te, "R4");
        put(1, 1, 2, 31, cyc - 1);
        fire(te, "R4");
        put(2, 0, 2, 31, cyc - 1);
        fire(te, "R4");
        put(3, 0, 2, 30, cyc - 1);
        expect_flt(1, 3, 2, 30, "R4");
        fire(te, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule